// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a 38-bit physical address by reading two 32-bit descriptors from memory. A requester presents the virtual address with an access kind (read, write or execute). The walker forms the directory entry address from a root frame register. It reads that entry and forms the page-table entry address from the frame the entry names. It then reads the page descriptor and either returns the physical address or reports a fault.

Every descriptor carries a 26-bit frame number and six control bits. When a walk succeeds and the page descriptor lacks the used flag, or lacks the dirty flag on a write, the walker posts a single write that stores the updated descriptor back into the table. Only one walk runs at a time. A busy output holds off further requests until the result has been delivered.

Top module: `pt_walker`

## Requirements
- R1: After reset, busy_o, done_o and mem_req_o are low.
- R2: The first memory read of a walk goes to byte address {root frame, va[31:22], 2'b00}, where the root frame is the value last loaded through root_we_i.
- R3: When the directory entry is present, the second read goes to {directory entry frame, va[21:12], 2'b00}.
- R4: A successful walk raises done_o for exactly one cycle, with fault_o = 2'b00 and pa_o = {page frame, va[11:0]}.
- R5: Descriptor layout: bits 31..6 hold the frame number, and bits 5..0 hold, from bit 5 down, present, dirty, used, read-allowed, write-allowed and execute-allowed.
- R6: A directory entry with present clear ends the walk after one read, with fault_o = 2'b01 and pa_o = 0.
- R7: A page descriptor with present clear ends the walk with fault_o = 2'b01 and pa_o = 0.
- R8: Access code 2'b00 (read) needs read-allowed, 2'b01 (write) needs write-allowed and 2'b10 (execute) needs execute-allowed. Code 2'b11 is never allowed. A denied access ends with fault_o = 2'b10, pa_o = 0 and no write.
- R9: On success, if the used bit is clear, or the access is a write and the dirty bit is clear, exactly one write goes to the page descriptor address. The written word has used set, and dirty also set for a write. Otherwise no write is issued.
- R10: busy_o is high from the cycle after a request is accepted until the cycle after done_o. A request presented while busy_o is high is ignored.
- R11: A root load presented while busy_o is high is ignored. A load while idle applies to the next walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request, accepted when busy_o is low |
| req_va_i | input | 32 | Virtual address to translate |
| req_acc_i | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| busy_o | output | 1 | A walk is in progress |
| root_we_i | input | 1 | Load the root frame register |
| root_pfn_i | input | 26 | Frame number of the page directory |
| mem_req_o | output | 1 | Memory access, valid for one cycle |
| mem_we_o | output | 1 | Access is a write (descriptor update) |
| mem_addr_o | output | 38 | Byte address of the descriptor |
| mem_wdata_o | output | 32 | Descriptor to write |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Descriptor returned by memory |
| done_o | output | 1 | One-cycle result strobe |
| fault_o | output | 2 | 00 none, 01 not present, 10 protection |
| pa_o | output | 38 | Physical address, zero unless the walk succeeded |

## Verification
A request accepted at a clock edge puts the directory read on mem_req_o during the next cycle. Each read response shown with mem_rvalid_i is followed one cycle later by either the next read, the descriptor write (which lasts one cycle) or the done strobe, and done_o comes one cycle after the write when there is one. The bench's memory model answers each read one cycle after the request and logs every access at the falling edge. The monitor compares the logged accesses and the result at the falling edge where done_o is high, so every sample lands in the cycle the state sequence puts it in. Requests and root loads injected during a walk have to leave both the access log and the result queue unchanged.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned IDX_W  = 10;
  localparam int unsigned PFN_W  = 26;
  localparam int unsigned CTL_W  = 6;
  localparam int unsigned DESC_W = PFN_W + CTL_W;
  localparam int unsigned PA_W   = PFN_W + OFF_W;
  localparam int unsigned ENT_SH = $clog2(DESC_W / 8);

  localparam logic [1:0] ACC_RD = 2'b00;
  localparam logic [1:0] ACC_WR = 2'b01;
  localparam logic [1:0] ACC_EX = 2'b10;

  localparam logic [1:0] FLT_NONE   = 2'b00;
  localparam logic [1:0] FLT_ABSENT = 2'b01;
  localparam logic [1:0] FLT_PROT   = 2'b10;

  localparam logic [DESC_W-1:0] USED_MASK = DESC_W'(1) << 3;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic present;
    logic dirty;
    logic used;
    logic rd_ok;
    logic wr_ok;
    logic ex_ok;
  } desc_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_UPDATE, ST_DONE
  } st_e;
endpackage

// File: rtl/pt_walk_addr.sv
module pt_walk_addr
  import pt_walk_pkg::*;
(
  input  logic [PFN_W-1:0] root_pfn_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [PFN_W-1:0] tbl_pfn_i,
  input  logic [PFN_W-1:0] page_pfn_i,
  output logic [PA_W-1:0]  l1_addr_o,
  output logic [PA_W-1:0]  l2_addr_o,
  output logic [PA_W-1:0]  pa_o
);
  localparam int unsigned DIR_LSB = VA_W - IDX_W;

  logic [IDX_W-1:0] dir_idx, tbl_idx;
  logic [OFF_W-1:0] pg_off;

  assign dir_idx = va_i[DIR_LSB +: IDX_W];
  assign tbl_idx = va_i[OFF_W +: IDX_W];
  assign pg_off  = va_i[OFF_W-1:0];

  assign l1_addr_o = {root_pfn_i, dir_idx, {ENT_SH{1'b0}}};
  assign l2_addr_o = {tbl_pfn_i, tbl_idx, {ENT_SH{1'b0}}};
  assign pa_o      = {page_pfn_i, pg_off};
endmodule

// File: rtl/pt_walk_check.sv
module pt_walk_check
  import pt_walk_pkg::*;
(
  input  logic [DESC_W-1:0] desc_i,
  input  logic [1:0]        acc_i,
  output logic              present_o,
  output logic              allow_o,
  output logic              wb_need_o,
  output logic [DESC_W-1:0] wb_desc_o
);
  desc_t d, nd;

  assign d         = desc_t'(desc_i);
  assign present_o = d.present;

  always_comb begin
    unique case (acc_i)
      ACC_RD:  allow_o = d.rd_ok;
      ACC_WR:  allow_o = d.wr_ok;
      ACC_EX:  allow_o = d.ex_ok;
      default: allow_o = 1'b0;
    endcase
  end

  always_comb begin
    nd      = d;
    nd.used = 1'b1;
    if (acc_i == ACC_WR) nd.dirty = 1'b1;
  end

  assign wb_need_o = (nd != d);
  assign wb_desc_o = nd;
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       rvalid_i,
  input  logic       present_i,
  input  logic       allow_i,
  input  logic       wb_need_i,
  output st_e        state_o,
  output logic [1:0] fault_o,
  output logic       cap_l1_o,
  output logic       cap_l2_o
);
  st_e        state_q, state_d;
  logic [1:0] fault_q, fault_d;

  assign cap_l1_o = (state_q == ST_L1_WAIT) && rvalid_i;
  assign cap_l2_o = (state_q == ST_L2_WAIT) && rvalid_i;

  always_comb begin
    state_d = state_q;
    fault_d = fault_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_L1_REQ;
        fault_d = FLT_NONE;
      end
      ST_L1_REQ: state_d = ST_L1_WAIT;
      ST_L1_WAIT: if (rvalid_i) begin
        if (!present_i) begin
          fault_d = FLT_ABSENT;
          state_d = ST_DONE;
        end else begin
          state_d = ST_L2_REQ;
        end
      end
      ST_L2_REQ: state_d = ST_L2_WAIT;
      ST_L2_WAIT: if (rvalid_i) begin
        if (!present_i) begin
          fault_d = FLT_ABSENT;
          state_d = ST_DONE;
        end else if (!allow_i) begin
          fault_d = FLT_PROT;
          state_d = ST_DONE;
        end else if (wb_need_i) begin
          state_d = ST_UPDATE;
        end else begin
          state_d = ST_DONE;
        end
      end
      ST_UPDATE: state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fault_q <= FLT_NONE;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
    end
  end

  assign state_o = state_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_va_i,
  input  logic [1:0]        req_acc_i,
  output logic              busy_o,
  input  logic              root_we_i,
  input  logic [PFN_W-1:0]  root_pfn_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [PA_W-1:0]   mem_addr_o,
  output logic [DESC_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [DESC_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic [1:0]        fault_o,
  output logic [PA_W-1:0]   pa_o
);
  st_e               state;
  logic [1:0]        fault;
  logic              start, cap_l1, cap_l2;
  logic              present, allow, wb_need;
  logic [DESC_W-1:0] wb_desc;
  logic [PA_W-1:0]   l1_addr, l2_addr, pa_full;

  logic [VA_W-1:0]   va_q;
  logic [1:0]        acc_q;
  logic [PFN_W-1:0]  root_q, tbl_pfn_q, page_pfn_q;
  logic [DESC_W-1:0] wb_q;

  assign start = req_valid_i && (state == ST_IDLE);

  pt_walk_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .rvalid_i  (mem_rvalid_i),
    .present_i (present),
    .allow_i   (allow),
    .wb_need_i (wb_need),
    .state_o   (state),
    .fault_o   (fault),
    .cap_l1_o  (cap_l1),
    .cap_l2_o  (cap_l2)
  );

  // decodes the raw response so the decision costs no extra cycle
  pt_walk_check u_check (
    .desc_i    (mem_rdata_i),
    .acc_i     (acc_q),
    .present_o (present),
    .allow_o   (allow),
    .wb_need_o (wb_need),
    .wb_desc_o (wb_desc)
  );

  pt_walk_addr u_addr (
    .root_pfn_i (root_q),
    .va_i       (va_q),
    .tbl_pfn_i  (tbl_pfn_q),
    .page_pfn_i (page_pfn_q),
    .l1_addr_o  (l1_addr),
    .l2_addr_o  (l2_addr),
    .pa_o       (pa_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q       <= '0;
      acc_q      <= ACC_RD;
      root_q     <= '0;
      tbl_pfn_q  <= '0;
      page_pfn_q <= '0;
      wb_q       <= '0;
    end else begin
      if (start) begin
        va_q  <= req_va_i;
        acc_q <= req_acc_i;
      end
      if (root_we_i && (state == ST_IDLE)) root_q <= root_pfn_i;
      if (cap_l1) tbl_pfn_q <= mem_rdata_i[DESC_W-1 -: PFN_W];
      if (cap_l2) begin
        page_pfn_q <= mem_rdata_i[DESC_W-1 -: PFN_W];
        wb_q       <= wb_desc;
      end
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state)
      ST_L1_REQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = l1_addr;
      end
      ST_L2_REQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = l2_addr;
      end
      ST_UPDATE: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = l2_addr;
        mem_wdata_o = wb_q;
      end
      default: ;
    endcase
  end

  assign busy_o  = (state != ST_IDLE);
  assign done_o  = (state == ST_DONE);
  assign fault_o = done_o ? fault : FLT_NONE;
  assign pa_o    = (done_o && fault == FLT_NONE) ? pa_full : '0;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import pt_walk_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [DESC_W-1:0] mem_wdata_o,
  input logic [1:0]        fault_o
);
  // R2
  mem_req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  // R2
  mem_req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  idle_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  // R9
  wb_used_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> ((mem_wdata_o & USED_MASK) != '0));

  // R9
  wb_then_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |=> (done_o && fault_o == FLT_NONE));
endmodule

bind pt_walker pt_walker_chk u_chk (.*);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  import pt_walk_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_valid, root_we, mem_rvalid;
  logic [31:0] req_va, mem_rdata;
  logic [1:0]  req_acc;
  logic [25:0] root_pfn;
  logic busy_o, mem_req_o, mem_we_o, done_o;
  logic [37:0] mem_addr_o, pa_o;
  logic [31:0] mem_wdata_o;
  logic [1:0]  fault_o;

  pt_walker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_va_i(req_va),
    .req_acc_i(req_acc), .busy_o(busy_o), .root_we_i(root_we), .root_pfn_i(root_pfn),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done_o), .fault_o(fault_o), .pa_o(pa_o)
  );

  typedef struct {
    logic [1:0]  flt;
    logic [37:0] pa;
    int          nrd;
    logic [37:0] a1;
    logic [37:0] a2;
    bit          wb;
    logic [31:0] wdat;
  } exp_t;

  logic [31:0] mem [logic [37:0]];
  logic [25:0] root_m;
  exp_t        exp_q[$];
  logic [37:0] rd_log[$];
  logic [37:0] wa_log[$];
  logic [31:0] wd_log[$];
  int n_chk = 0, n_fail = 0, done_cnt = 0, issued = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rdm(input logic [37:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // R5: frame in 31..6, then P D U R W X from bit 5 down
  function automatic exp_t model(input logic [31:0] va, input logic [1:0] acc);
    exp_t e;
    logic [31:0] d1, d2, nd;
    bit ok;
    e.flt = FLT_NONE; e.pa = '0; e.wb = 0; e.wdat = '0; e.a2 = '0;
    e.a1 = {root_m, va[31:22], 2'b00};
    d1 = rdm(e.a1);
    e.nrd = 1;
    if (!d1[5]) begin
      e.flt = FLT_ABSENT;
      return e;
    end
    e.a2 = {d1[31:6], va[21:12], 2'b00};
    d2 = rdm(e.a2);
    e.nrd = 2;
    if (!d2[5]) begin
      e.flt = FLT_ABSENT;
      return e;
    end
    ok = (acc == 2'b00) ? d2[2] : (acc == 2'b01) ? d2[1] : (acc == 2'b10) ? d2[0] : 1'b0;
    if (!ok) begin
      e.flt = FLT_PROT;
      return e;
    end
    nd = d2 | 32'h8 | ((acc == 2'b01) ? 32'h10 : 32'h0);
    e.wb = (nd != d2);
    e.wdat = nd;
    e.pa = {d2[31:6], va[11:0]};
    return e;
  endfunction

  task automatic map(input logic [25:0] root, input logic [9:0] dir, input logic [9:0] tbl,
                     input logic [5:0] ctl, input logic [25:0] pfn);
    logic [25:0] tf;
    tf = 26'h2000 + 26'(dir) + (root[0] ? 26'h800 : 26'h0);
    mem[{root, dir, 2'b00}] = {tf, 6'b100000};
    mem[{tf, tbl, 2'b00}]   = {pfn, ctl};
  endtask

  // memory model: answers each read one cycle after the request
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_req_o) begin
        if (mem_we_o) begin
          mem[mem_addr_o] = mem_wdata_o;
          wa_log.push_back(mem_addr_o);
          wd_log.push_back(mem_wdata_o);
        end else begin
          logic [37:0] a;
          a = mem_addr_o;
          rd_log.push_back(a);
          @(negedge clk);
          mem_rvalid = 1'b1;
          mem_rdata  = rdm(a);
        end
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (done_o) begin
        done_cnt++;
        if (exp_q.size() == 0) begin
          chk("R10 unexpected done", 1, 0);
        end else begin
          exp_t e;
          string tag;
          e = exp_q.pop_front();
          tag = (e.flt == FLT_ABSENT) ? ((e.nrd == 1) ? "R6" : "R7") :
                (e.flt == FLT_PROT) ? "R8" : "R4";
          chk({tag, " fault"}, fault_o, e.flt);
          chk({tag, " pa"}, pa_o, e.pa);
          chk({tag, " read count"}, rd_log.size(), e.nrd);
          if (rd_log.size() > 0) chk("R2 directory address", rd_log[0], e.a1);
          if (e.nrd == 2 && rd_log.size() > 1) chk("R3 table address", rd_log[1], e.a2);
          chk("R9 write count", wa_log.size(), e.wb ? 1 : 0);
          if (e.wb && wa_log.size() > 0) begin
            chk("R9 write address", wa_log[0], e.a2);
            chk("R5 write data", wd_log[0], e.wdat);
          end
        end
        rd_log.delete(); wa_log.delete(); wd_log.delete();
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [1:0] acc, input bit poke = 0);
    while (busy_o) @(negedge clk);
    exp_q.push_back(model(va, acc));
    issued++;
    req_va = va; req_acc = acc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      // R10 R11: both must be ignored during the walk
      req_valid = 1'b1; req_va = ~va; req_acc = 2'b00;
      root_we = 1'b1; root_pfn = ~root_m;
      @(negedge clk);
      req_valid = 1'b0; root_we = 1'b0;
    end
    while (busy_o) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  localparam logic [25:0] ROOT_A = 26'h00A1;
  localparam logic [25:0] ROOT_B = 26'h3FFFF00;

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; root_we = 1'b0; root_pfn = '0;
    req_va = '0; req_acc = '0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 mem_req", mem_req_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    root_we = 1'b1; root_pfn = ROOT_A;
    @(negedge clk);
    root_we = 1'b0; root_m = ROOT_A;

    map(ROOT_A, 10'd3, 10'd5, 6'b101100, 26'h3ABCDE);
    map(ROOT_A, 10'd3, 10'd6, 6'b100100, 26'h1234);
    map(ROOT_A, 10'd7, 10'd0, 6'b100010, 26'h3FFFFFF);
    map(ROOT_A, 10'd7, 10'd1, 6'b101010, 26'h0F0F0F);
    map(ROOT_A, 10'd7, 10'd2, 6'b100001, 26'h000777);
    map(ROOT_A, 10'd0, 10'd0, 6'b111100, 26'h1);
    map(ROOT_A, 10'd1023, 10'd1023, 6'b111111, 26'h2AAAAAA);

    walk({10'd3, 10'd5, 12'h123}, 2'b00);        // R4 read, no update
    walk({10'd3, 10'd6, 12'hABC}, 2'b00);        // R9 used set
    walk({10'd3, 10'd6, 12'h001}, 2'b00);        // R9 nothing to update
    walk({10'd7, 10'd0, 12'hFFF}, 2'b01);        // R9 used and dirty
    walk({10'd7, 10'd0, 12'h010}, 2'b01);        // R9 no second update
    walk({10'd7, 10'd1, 12'h555}, 2'b01);        // R9 dirty only
    walk({10'd7, 10'd2, 12'h777}, 2'b10);        // R8 execute allowed
    walk({10'd7, 10'd2, 12'h777}, 2'b00);        // R8 read denied
    walk({10'd0, 10'd0, 12'h000}, 2'b01);        // R8 write denied
    walk({10'd0, 10'd0, 12'h000}, 2'b10);        // R8 execute denied
    walk({10'd0, 10'd0, 12'h000}, 2'b11);        // R8 reserved code
    walk({10'd9, 10'd0, 12'h000}, 2'b00);        // R6 directory absent
    walk({10'd3, 10'd7, 12'h000}, 2'b00);        // R7 page absent
    walk(32'hFFFF_FFFF, 2'b00);                  // R4 top corner
    walk(32'hFFFF_FFFF, 2'b01);                  // R9 dirty already set
    walk({10'd3, 10'd5, 12'h456}, 2'b00, 1'b1);  // R10 R11 pokes while busy
    walk({10'd3, 10'd5, 12'h789}, 2'b00);        // R11 root unchanged

    // R11: load while idle takes effect
    root_we = 1'b1; root_pfn = ROOT_B;
    @(negedge clk);
    root_we = 1'b0; root_m = ROOT_B;
    map(ROOT_B, 10'd3, 10'd5, 6'b100100, 26'h55);
    walk({10'd3, 10'd5, 12'h321}, 2'b00);

    repeat (10) @(negedge clk);
    chk("R10 done count", done_cnt, issued);
    chk("R10 idle at end", busy_o, 0);
    finish_run();
  end
endmodule